// File: doc/BRIEF.md
# Fully Associative Write-Back Data Cache

This block is a four-line data cache between a processor port that addresses bytes and a backing memory port that moves whole four-byte lines. It has no index field. A block may sit in any line, and the request tag is compared against all four stored tags in the same cycle. Loads and stores of a single byte or of a whole word are served from the cached line. A miss allocates a line and fetches the full line from memory. Stores stay in the cache until their line is evicted, and are then written back.

Replacement is driven by a recency rank per line. The most recently used line holds rank 0 and the least recently used line holds rank 3. An empty line is always preferred over evicting a valid one.

Both ports use a request/ready handshake. The processor holds `cpu_req` and its request fields stable until `cpu_ready` pulses. The cache holds `mem_req` and its fields stable until `mem_ready` pulses.

Top module: `fa_wb_cache`

## Requirements
- R1: A 12-bit request address splits into a tag (bits 11:2) and a byte offset (bits 1:0). `mem_addr` carries the 10-bit tag of the line being moved. Byte k of a line occupies bits [8k+7:8k] of every 32-bit line value.
- R2: After reset every line is invalid, the recency ranks are line i = rank i, and both `cpu_ready` and `mem_req` are low while no request is present.
- R3: A line whose valid flag is clear never hits. For example, an access to address 0x000 right after reset misses, even though the reset value of every stored tag is 0.
- R4: A hit raises `cpu_ready` in the same cycle the request is presented, with no memory request. A byte load returns the addressed byte zero-extended in bits 7:0.
- R5: A miss performs exactly one line read at the request tag and then completes. Later accesses to any byte of that line hit.
- R6: On a miss while some line is invalid, the lowest-numbered invalid line is filled.
- R7: Each completed access sets its line to rank 0 and adds one to every line whose rank was below that line's previous rank. On a miss with all lines valid, the victim is the line of rank 3.
- R8: A store hit changes only the cached bytes and marks the line dirty. No memory write occurs.
- R9: Evicting a dirty line first writes its four bytes to memory at its own tag. The fill read comes only after that write.
- R10: Evicting a clean line performs no memory write.
- R11: A store miss allocates. The line is filled from memory, the store bytes are merged in, and the line becomes dirty.
- R12: When `cpu_size` is 1, the access is a word: a load returns the whole line and a store replaces all four bytes. The offset bits are ignored. When `cpu_size` is 0, the access is a single byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_size | input | 1 | 1 = word, 0 = byte |
| cpu_addr | input | 12 | Byte address |
| cpu_wdata | input | 32 | Store data (byte stores use bits 7:0) |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = line write-back, 0 = line fill |
| mem_addr | output | 10 | Line tag of the transfer |
| mem_wdata | output | 32 | Victim line data |
| mem_ready | input | 1 | Memory completes the transfer |
| mem_rdata | input | 32 | Fill line data, valid with mem_ready |

## Verification
Two functions share a single clock edge on a store hit. The byte merge sets the dirty flag, and the recency update reorders every rank. A store to the least recent line is therefore followed by misses that show whether that line moved to rank 0 and whether its dirty state survived. A second pairing arises when a store misses into a dirty victim: the write-back, the fill and the store merge then run back to back. The bench judges each memory transaction against a reference model, using its order, its tag and its data. A long pseudo-random mix of byte and word loads and stores over six tags exercises these collisions repeatedly.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } fa_state_e;

endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
  parameter int LINES = 4,
  parameter int TAG_W = 10,
  parameter int IW    = $clog2(LINES)
) (
  input  logic [LINES-1:0] line_valid,
  input  logic [TAG_W-1:0] line_tag [LINES],
  input  logic [TAG_W-1:0] req_tag,
  output logic             hit,
  output logic [LINES-1:0] hit_vec,
  output logic [IW-1:0]    hit_idx
);

  // one comparator per line, all in parallel
  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign hit_vec[g] = line_valid[g] && (line_tag[g] == req_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
  end

endmodule

// File: rtl/fa_age_track.sv
module fa_age_track #(
  parameter int LINES = 4,
  parameter int IW    = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] age [LINES],
  output logic [IW-1:0] oldest_idx
);

  localparam logic [IW-1:0] OLDEST = IW'(LINES - 1);

  // rank after an access: touched line to 0, younger-than-it lines age by one
  function automatic logic [IW-1:0] aged(input logic [IW-1:0] cur,
                                         input logic [IW-1:0] pivot,
                                         input logic          is_touched);
    if (is_touched)     return '0;
    else if (cur < pivot) return cur + IW'(1);
    else                return cur;
  endfunction

  logic [IW-1:0] pivot_age;
  assign pivot_age = age[touch_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) age[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < LINES; i++)
        age[i] <= aged(age[i], pivot_age, touch_idx == IW'(i));
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (age[i] == OLDEST) oldest_idx = IW'(i);
    end
  end

  // ranks stay a permutation: each rank value held by exactly one line
  for (genvar v = 0; v < LINES; v++) begin : g_perm
    logic [LINES-1:0] holds_v;
    for (genvar l = 0; l < LINES; l++) begin : g_l
      assign holds_v[l] = (age[l] == IW'(v));
    end
    p_age_perm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(holds_v) == 1);
  end

  p_touch_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> age[$past(touch_idx)] == '0);

endmodule

// File: rtl/fa_victim_pick.sv
module fa_victim_pick #(
  parameter int LINES = 4,
  parameter int IW    = $clog2(LINES)
) (
  input  logic [LINES-1:0] line_valid,
  input  logic [IW-1:0]    oldest_idx,
  output logic [IW-1:0]    victim_idx,
  output logic             victim_free
);

  // lowest-numbered empty line, scanning downward so index 0 wins
  function automatic logic [IW-1:0] first_free(input logic [LINES-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!v[i]) r = IW'(i);
    end
    return r;
  endfunction

  assign victim_free = ~&line_valid;
  assign victim_idx  = victim_free ? first_free(line_valid) : oldest_idx;

endmodule

// File: rtl/fa_wb_cache.sv
module fa_wb_cache
  import fa_cache_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 4,
  parameter int LINES      = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_req,
  input  logic                       cpu_we,
  input  logic                       cpu_size,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic [8*LINE_BYTES-1:0]    cpu_wdata,
  output logic                       cpu_ready,
  output logic [8*LINE_BYTES-1:0]    cpu_rdata,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] mem_addr,
  output logic [8*LINE_BYTES-1:0]    mem_wdata,
  input  logic                       mem_ready,
  input  logic [8*LINE_BYTES-1:0]    mem_rdata
);

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int LINE_W = 8 * LINE_BYTES;
  localparam int IW     = $clog2(LINES);

  // byte or whole-line read out of a line
  function automatic logic [LINE_W-1:0] load_pick(input logic [LINE_W-1:0] line,
                                                  input logic [OFF_W-1:0]  off,
                                                  input logic              word);
    logic [LINE_W-1:0] r;
    r = '0;
    if (word) r = line;
    else      r[7:0] = line[8*off +: 8];
    return r;
  endfunction

  // store data merged into a line
  function automatic logic [LINE_W-1:0] store_merge(input logic [LINE_W-1:0] line,
                                                    input logic [OFF_W-1:0]  off,
                                                    input logic              word,
                                                    input logic [LINE_W-1:0] wd);
    logic [LINE_W-1:0] r;
    r = line;
    if (word) r = wd;
    else      r[8*off +: 8] = wd[7:0];
    return r;
  endfunction

  // line storage
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];
  logic [LINES-1:0]  valid_q, dirty_q;

  fa_state_e state_q, state_d;
  logic [IW-1:0]    vic_q;
  logic [TAG_W-1:0] miss_tag_q;

  logic [TAG_W-1:0] req_tag;
  logic [OFF_W-1:0] req_off;
  assign req_tag = cpu_addr[ADDR_W-1:OFF_W];
  assign req_off = cpu_addr[OFF_W-1:0];

  // named internal events
  logic             hit;
  logic [LINES-1:0] hit_vec;
  logic [IW-1:0]    hit_idx;
  logic [IW-1:0]    age [LINES];
  logic [IW-1:0]    oldest_idx, vic_idx;
  logic             vic_free;
  logic             in_idle, access_done, store_hit, miss_start;
  logic             wb_done, fill_done, vic_dirty;

  fa_tag_match #(.LINES(LINES), .TAG_W(TAG_W), .IW(IW)) u_match (
    .line_valid (valid_q),
    .line_tag   (tag_q),
    .req_tag    (req_tag),
    .hit        (hit),
    .hit_vec    (hit_vec),
    .hit_idx    (hit_idx)
  );

  fa_age_track #(.LINES(LINES), .IW(IW)) u_ages (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch      (access_done),
    .touch_idx  (hit_idx),
    .age        (age),
    .oldest_idx (oldest_idx)
  );

  fa_victim_pick #(.LINES(LINES), .IW(IW)) u_victim (
    .line_valid (valid_q),
    .oldest_idx (oldest_idx),
    .victim_idx (vic_idx),
    .victim_free(vic_free)
  );

  assign in_idle     = (state_q == ST_IDLE);
  assign access_done = in_idle && cpu_req && hit;
  assign store_hit   = access_done && cpu_we;
  assign miss_start  = in_idle && cpu_req && !hit;
  assign wb_done     = (state_q == ST_WB) && mem_ready;
  assign fill_done   = (state_q == ST_FILL) && mem_ready;
  assign vic_dirty   = valid_q[vic_idx] && dirty_q[vic_idx];

  assign cpu_ready = access_done;
  assign cpu_rdata = load_pick(data_q[hit_idx], req_off, cpu_size);

  assign mem_req   = !in_idle;
  assign mem_we    = (state_q == ST_WB);
  assign mem_addr  = (state_q == ST_WB) ? tag_q[vic_q] : miss_tag_q;
  assign mem_wdata = data_q[vic_q];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (miss_start) state_d = vic_dirty ? ST_WB : ST_FILL;
      ST_WB:   if (mem_ready)  state_d = ST_FILL;
      ST_FILL: if (mem_ready)  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      vic_q      <= '0;
      miss_tag_q <= '0;
    end else begin
      state_q <= state_d;
      if (miss_start) begin
        vic_q      <= vic_idx;
        miss_tag_q <= req_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (fill_done && vic_q == IW'(i)) begin
          tag_q[i]   <= miss_tag_q;
          data_q[i]  <= mem_rdata;
          valid_q[i] <= 1'b1;
          dirty_q[i] <= 1'b0;
        end else if (wb_done && vic_q == IW'(i)) begin
          dirty_q[i] <= 1'b0;
        end else if (store_hit && hit_idx == IW'(i)) begin
          data_q[i]  <= store_merge(data_q[i], req_off, cpu_size, cpu_wdata);
          dirty_q[i] <= 1'b1;
        end
      end
    end
  end

  // at most one line may match a tag
  p_hit_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // a hit completes without touching memory
  p_ready_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_req);

  // a fill leaves its line valid with the missed tag
  p_fill_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> valid_q[$past(vic_q)] && tag_q[$past(vic_q)] == $past(miss_tag_q));

  // store completion leaves the line dirty
  p_store_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we) |=> dirty_q[$past(hit_idx)]);

  // a fill never overwrites unsaved data
  p_clean_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL) |-> !(valid_q[vic_q] && dirty_q[vic_q]));

  // an empty line is taken while one exists
  p_vic_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_start && !(&valid_q)) |-> !valid_q[vic_idx]);

  // full cache evicts the least recent line
  p_vic_oldest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_start && (&valid_q)) |-> age[vic_idx] == IW'(LINES - 1));

endmodule

// File: tb/tb_fa_wb_cache.sv
module tb_fa_wb_cache;

  localparam int CLK_NS  = 10;
  localparam int MEM_LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_size = 1'b0;
  logic [11:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #(CLK_NS/2) clk = ~clk;

  fa_wb_cache dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] bmem [1024];   // backing store seen by the design
  logic [31:0] rmem [1024];   // reference memory of the model

  // transaction log of the memory port
  int          n_log = 0;
  logic        lg_we   [16];
  logic [9:0]  lg_addr [16];
  logic [31:0] lg_data [16];
  int          lat_cnt = 0;

  // reference cache state
  logic        m_valid [4];
  logic        m_dirty [4];
  logic [9:0]  m_tag   [4];
  logic [31:0] m_data  [4];
  int          m_age   [4];

  function automatic logic [31:0] seed_word(input int t);
    logic [9:0] a;
    a = 10'(t);
    return {a[7:0] ^ 8'h3C, a[9:2] + 8'h11, 8'(a * 7), ~a[7:0]};
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
      lat_cnt   = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
    end else if (mem_req) begin
      lat_cnt++;
      if (lat_cnt >= MEM_LAT) begin
        lat_cnt   = 0;
        mem_ready = 1'b1;
        mem_rdata = bmem[mem_addr];
        if (n_log < 16) begin
          lg_we[n_log]   = mem_we;
          lg_addr[n_log] = mem_addr;
          lg_data[n_log] = mem_we ? mem_wdata : bmem[mem_addr];
        end
        n_log++;
        if (mem_we) bmem[mem_addr] = mem_wdata;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // one access: predict with the model, drive, compare
  task automatic access(input bit we, input bit word, input logic [11:0] addr,
                        input logic [31:0] wd, input string req);
    logic [9:0]  tg;
    logic [1:0]  off;
    int          line, prev, cycles, e_n;
    bit          exp_hit;
    logic        e_we   [2];
    logic [9:0]  e_addr [2];
    logic [31:0] e_data [2];
    logic [31:0] e_rd, got;
    tg = addr[11:2];
    off = word ? 2'd0 : addr[1:0];
    line = -1;
    e_n = 0;
    for (int i = 0; i < 4; i++) if (m_valid[i] && m_tag[i] == tg) line = i;
    exp_hit = (line >= 0);
    if (!exp_hit) begin
      for (int i = 3; i >= 0; i--) if (!m_valid[i]) line = i;
      if (line < 0) for (int i = 0; i < 4; i++) if (m_age[i] == 3) line = i;
      if (m_valid[line] && m_dirty[line]) begin
        e_we[e_n] = 1'b1; e_addr[e_n] = m_tag[line]; e_data[e_n] = m_data[line];
        rmem[m_tag[line]] = m_data[line];
        e_n++;
      end
      e_we[e_n] = 1'b0; e_addr[e_n] = tg; e_data[e_n] = rmem[tg];
      e_n++;
      m_valid[line] = 1'b1; m_dirty[line] = 1'b0;
      m_tag[line] = tg; m_data[line] = rmem[tg];
    end
    e_rd = word ? m_data[line] : {24'h0, m_data[line][8*off +: 8]};
    if (we) begin
      if (word) m_data[line] = wd;
      else      m_data[line][8*off +: 8] = wd[7:0];
      m_dirty[line] = 1'b1;
    end
    prev = m_age[line];
    for (int i = 0; i < 4; i++) begin
      if (i == line)          m_age[i] = 0;
      else if (m_age[i] < prev) m_age[i] = m_age[i] + 1;
    end

    n_log     = 0;
    cpu_req   = 1'b1;
    cpu_we    = we;
    cpu_size  = word;
    cpu_addr  = addr;
    cpu_wdata = wd;
    cycles    = 0;
    #1;
    while (!cpu_ready && cycles < 300) begin
      @(negedge clk);
      #1;
      cycles++;
    end
    got = cpu_rdata;
    check(cycles < 300, req, "request completes", 32'(cycles), 32'd0);
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;

    if (exp_hit) check(cycles == 0, "R4", "hit ready latency", 32'(cycles), 32'd0);
    else         check(cycles > 0, req, "miss stalls", 32'(cycles), 32'd1);
    check(n_log == e_n, req, "memory transfer count", 32'(n_log), 32'(e_n));
    for (int k = 0; k < e_n && k < n_log; k++) begin
      check(lg_we[k] == e_we[k], req, "transfer direction", 32'(lg_we[k]), 32'(e_we[k]));
      check(lg_addr[k] == e_addr[k], req, "transfer tag", 32'(lg_addr[k]), 32'(e_addr[k]));
      check(lg_data[k] == e_data[k], req, "transfer data", lg_data[k], e_data[k]);
    end
    if (!we) check(got == e_rd, req, "load data", got, e_rd);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL R5 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int a = 0; a < 1024; a++) begin
      bmem[a] = seed_word(a);
      rmem[a] = seed_word(a);
    end
    for (int i = 0; i < 4; i++) begin
      m_valid[i] = 1'b0; m_dirty[i] = 1'b0; m_tag[i] = '0; m_data[i] = '0; m_age[i] = i;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(cpu_ready == 1'b0, "R2", "ready idle after reset", 32'(cpu_ready), 32'd0);
    check(mem_req == 1'b0, "R2", "no memory request after reset", 32'(mem_req), 32'd0);
    @(negedge clk);

    // R3: stored tag 0 of an invalid line must not hit
    access(1'b0, 1'b0, 12'h000, 32'h0, "R3");
    // R6: remaining lines fill lowest-first; R5 fetches whole lines
    access(1'b0, 1'b0, 12'h005, 32'h0, "R6");
    access(1'b0, 1'b0, 12'h00A, 32'h0, "R6");
    access(1'b0, 1'b0, 12'h00F, 32'h0, "R6");
    // R1: every byte of every line, hit after fill
    for (int t = 0; t < 4; t++)
      for (int o = 0; o < 4; o++)
        access(1'b0, 1'b0, 12'((t << 2) | o), 32'h0, "R1");
    // R12: word loads, offset ignored
    for (int t = 0; t < 4; t++) access(1'b0, 1'b1, 12'((t << 2) | 3), 32'h0, "R12");
    // R8: store hit stays in cache
    access(1'b1, 1'b0, 12'h006, 32'h000000A7, "R8");
    access(1'b0, 1'b0, 12'h006, 32'h0, "R8");
    access(1'b1, 1'b1, 12'h00D, 32'hCAFE1234, "R12");
    access(1'b0, 1'b1, 12'h00C, 32'h0, "R12");
    // R7: reorder, then evict the least recent (tag 2, clean)
    access(1'b0, 1'b0, 12'h008, 32'h0, "R7");
    access(1'b0, 1'b0, 12'h000, 32'h0, "R7");
    access(1'b0, 1'b0, 12'h00C, 32'h0, "R7");
    access(1'b0, 1'b0, 12'h004, 32'h0, "R7");
    access(1'b0, 1'b0, 12'h401, 32'h0, "R10");
    access(1'b0, 1'b0, 12'h009, 32'h0, "R7");
    // R9: dirty line made least recent, then evicted
    access(1'b1, 1'b0, 12'h402, 32'h0000005E, "R9");
    access(1'b0, 1'b0, 12'h000, 32'h0, "R9");
    access(1'b0, 1'b0, 12'h004, 32'h0, "R9");
    access(1'b0, 1'b0, 12'h008, 32'h0, "R9");
    access(1'b0, 1'b0, 12'h0C4, 32'h0, "R9");
    access(1'b0, 1'b1, 12'h400, 32'h0, "R9");
    // R11: store misses, byte and word
    access(1'b1, 1'b0, 12'h7F3, 32'h00000091, "R11");
    access(1'b0, 1'b1, 12'h7F0, 32'h0, "R11");
    access(1'b1, 1'b1, 12'h3A0, 32'h0BADF00D, "R11");
    access(1'b0, 1'b0, 12'h3A2, 32'h0, "R11");
    // R7: pseudo-random mix over six tags
    lfsr = 16'hACE1;
    for (int n = 0; n < 800; n++) begin
      logic [9:0] t;
      logic [1:0] o;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      t = 10'((32'(lfsr[7:0]) % 6) * 97 + 3);
      o = lfsr[9:8];
      access(lfsr[10], lfsr[11], {t, o}, {lfsr, ~lfsr}, "R7");
    end
    summary();
    $finish;
  end

endmodule